// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Match Scheduler

This block decides, once per cell slot, which inputs of a four-port input-queued switch may send through the crossbar to which outputs. Each input keeps one queue per output, and the caller presents a flat request matrix with a bit set wherever such a queue holds data. The scheduler then runs a few request/grant/accept rounds and returns a one-to-one pairing of inputs to outputs.

Every output owns a rotating grant arbiter, and every input owns a rotating accept arbiter. Each arbiter is a programmable priority encoder whose starting point is a stored pointer. A pointer moves only when a grant is accepted in the first round, and it moves to the position just past the partner that was matched. The partner that was served last therefore drops to the lowest priority. As a result the arbiters drift apart, and under full uniform load they settle into a rotation that pairs every port. Later rounds fill the remaining gaps among ports that are still free and never disturb pairs already made.

A slot starts with a one-cycle start pulse, which captures the request matrix and the round count. The result is valid, and stays held, from the cycle in which done pulses until the next start is taken.

Top module: `islip_sched`

## Requirements
- R1: After reset, done_o and busy_o are 0, match_o is all zero, and every grant and accept pointer is 0. With every request set and one round, the first slot therefore pairs only input 0 with output 0.
- R2: match_o uses bit i*N+j to mean "input i sends to output j". Every row and every column has at most one bit set, and a set bit only appears where the captured request bit req_i[i*N+j] was 1.
- R3: In each round, every free output grants the free requesting input that comes first when counting upward, wrapping round, from that output's grant pointer.
- R4: In each round, every free input accepts the granting output that comes first when counting upward, wrapping round, from that input's accept pointer.
- R5: Pointers change only for grants accepted in the first round of a slot. The grant pointer of the output becomes (matched input + 1) mod N, and the accept pointer of the input becomes (matched output + 1) mod N. All other pointers are kept.
- R6: Rounds after the first consider only inputs and outputs that are still unmatched, and pairs made earlier in the slot are kept.
- R7: A start taken in idle captures req_i and iters_i and raises busy_o at the next edge. An iters_i value of 0 counts as 1, and any value above N counts as N. After that many rounds, done_o is high for exactly one cycle, busy_o falls in the same cycle, and match_o stays held afterwards.
- R8: start_i, req_i and iters_i are ignored while busy_o is high.
- R9: match_vld_o[i] is 1 exactly when input i is matched, and in that case match_idx_o[i*NW +: NW] holds the index of its output.
- R10: With every request set and a single round per slot, the pairing is complete (N pairs) in every slot from slot N+1 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a slot when idle |
| iters_i | input | CW | Rounds to run this slot (clamped to 1..N) |
| req_i | input | N*N | Request matrix, bit i*N+j = input i has cells for output j |
| busy_o | output | 1 | Rounds in progress |
| done_o | output | 1 | One-cycle pulse when the slot's pairing is final |
| match_o | output | N*N | Pairing matrix, same bit layout as req_i |
| match_vld_o | output | N | Input i is paired |
| match_idx_o | output | N*NW | Output index paired to input i, NW bits per input |

## Verification
A full request matrix with one round per slot starts from the reset pointers. The first slot shows whether the pointers clear to zero, and the following slots show whether the pointers desynchronise into complete pairings. Constrained-random sparse and dense matrices with round counts from 0 to 5 are compared slot by slot against a bench model that keeps its own pointer copies. This separates the grant order, the accept order, the first-round-only pointer rule and the preserving of earlier pairs, and it also covers count clamping. Some slots inject a start pulse with a different matrix while busy, which exposes any capture during a running slot. Sparse single-row and single-column matrices exercise the pointer wrap.

// File: rtl/islip_pkg.sv
package islip_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_state_e;

endpackage

// File: rtl/islip_ppe.sv
// Programmable priority encoder: picks the first set request at or after ptr_i,
// wrapping round (R3, R4).
module islip_ppe #(
    parameter int N  = 4,
    parameter int NW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [NW-1:0] ptr_i,
    output logic [N-1:0]  gnt_o,
    output logic [NW-1:0] idx_o,
    output logic          any_o
);

    always_comb begin
        gnt_o = '0;
        idx_o = '0;
        any_o = 1'b0;
        for (int k = 0; k < N; k++) begin
            int p;
            p = int'(ptr_i) + k;
            if (p >= N) p = p - N;
            if (!any_o && req_i[p]) begin
                any_o    = 1'b1;
                gnt_o[p] = 1'b1;
                idx_o    = NW'(p);
            end
        end
    end

endmodule

// File: rtl/islip_round.sv
// One request/grant/accept round among free ports (R3, R4, R6).
module islip_round #(
    parameter int N  = 4,
    parameter int NW = $clog2(N)
) (
    input  logic [N*N-1:0]  req_i,
    input  logic [N-1:0]    in_free_i,
    input  logic [N-1:0]    out_free_i,
    input  logic [N*NW-1:0] gptr_i,
    input  logic [N*NW-1:0] aptr_i,
    output logic [N*N-1:0]  pair_o,
    output logic [N-1:0]    in_hit_o,
    output logic [N*NW-1:0] in_idx_o,
    output logic [N-1:0]    out_hit_o,
    output logic [N*NW-1:0] out_idx_o
);

    logic [N*N-1:0] grant_mat;

    // grant side: one encoder per output, over inputs
    for (genvar j = 0; j < N; j++) begin : g_out
        logic [N-1:0] col_req;
        logic [N-1:0] col_gnt;
        logic         col_any;
        for (genvar i = 0; i < N; i++) begin : g_col
            assign col_req[i]         = req_i[i*N+j] & in_free_i[i] & out_free_i[j];
            assign grant_mat[i*N+j]   = col_gnt[i];
        end
        islip_ppe #(.N(N), .NW(NW)) u_gnt (
            .req_i (col_req),
            .ptr_i (gptr_i[j*NW +: NW]),
            .gnt_o (col_gnt),
            .idx_o (out_idx_o[j*NW +: NW]),
            .any_o (col_any)
        );
    end

    // accept side: one encoder per input, over outputs
    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0] row_gnt;
        logic [N-1:0] row_acc;
        assign row_gnt = grant_mat[i*N +: N];
        islip_ppe #(.N(N), .NW(NW)) u_acc (
            .req_i (row_gnt),
            .ptr_i (aptr_i[i*NW +: NW]),
            .gnt_o (row_acc),
            .idx_o (in_idx_o[i*NW +: NW]),
            .any_o (in_hit_o[i])
        );
        assign pair_o[i*N +: N] = row_acc;
    end

    always_comb begin
        out_hit_o = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                out_hit_o[j] = out_hit_o[j] | pair_o[i*N+j];
            end
        end
    end

endmodule

// File: rtl/islip_sched.sv
module islip_sched
    import islip_pkg::*;
#(
    parameter int N  = 4,
    parameter int NW = $clog2(N),
    parameter int CW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CW-1:0]   iters_i,
    input  logic [N*N-1:0]  req_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [N*N-1:0]  match_o,
    output logic [N-1:0]    match_vld_o,
    output logic [N*NW-1:0] match_idx_o
);

    typedef struct packed {
        sched_state_e    st;
        logic            done;
        logic            first;
        logic [CW-1:0]   left;
        logic [N*N-1:0]  req;
        logic [N*N-1:0]  match;
        logic [N-1:0]    in_m;
        logic [N-1:0]    out_m;
        logic [N*NW-1:0] idx;
        logic [N*NW-1:0] gptr;
        logic [N*NW-1:0] aptr;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [N*N-1:0]  pair;
    logic [N-1:0]    in_hit;
    logic [N*NW-1:0] in_idx;
    logic [N-1:0]    out_hit;
    logic [N*NW-1:0] out_idx;

    islip_round #(.N(N), .NW(NW)) u_round (
        .req_i      (st_q.req),
        .in_free_i  (~st_q.in_m),
        .out_free_i (~st_q.out_m),
        .gptr_i     (st_q.gptr),
        .aptr_i     (st_q.aptr),
        .pair_o     (pair),
        .in_hit_o   (in_hit),
        .in_idx_o   (in_idx),
        .out_hit_o  (out_hit),
        .out_idx_o  (out_idx)
    );

    function automatic logic [NW-1:0] step_ptr(input logic [NW-1:0] x);
        return (int'(x) == N - 1) ? '0 : x + 1'b1;
    endfunction

    function automatic logic [CW-1:0] clamp_rounds(input logic [CW-1:0] v);
        if (v == '0)          return CW'(1);
        else if (int'(v) > N) return CW'(N);
        else                  return v;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.st == ST_IDLE) begin
            if (start_i) begin                      // R7 capture; R8 only here
                st_d.st    = ST_RUN;
                st_d.req   = req_i;
                st_d.left  = clamp_rounds(iters_i);
                st_d.first = 1'b1;
                st_d.match = '0;
                st_d.in_m  = '0;
                st_d.out_m = '0;
                st_d.idx   = '0;
            end
        end else begin
            st_d.match = st_q.match | pair;         // R6 keep earlier pairs
            st_d.in_m  = st_q.in_m | in_hit;
            st_d.out_m = st_q.out_m | out_hit;
            for (int i = 0; i < N; i++) begin
                if (in_hit[i]) begin
                    st_d.idx[i*NW +: NW] = in_idx[i*NW +: NW];   // R9
                    if (st_q.first) begin           // R5 accept pointer
                        st_d.aptr[i*NW +: NW] = step_ptr(in_idx[i*NW +: NW]);
                    end
                end
            end
            for (int j = 0; j < N; j++) begin
                if (out_hit[j] && st_q.first) begin // R5 grant pointer
                    st_d.gptr[j*NW +: NW] = step_ptr(out_idx[j*NW +: NW]);
                end
            end
            st_d.first = 1'b0;
            st_d.left  = st_q.left - 1'b1;
            if (st_q.left == CW'(1)) begin
                st_d.st   = ST_IDLE;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_IDLE, done: 1'b0, first: 1'b0, left: '0,
                      req: '0, match: '0, in_m: '0, out_m: '0, idx: '0,
                      gptr: '0, aptr: '0};              // R1
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = (st_q.st == ST_RUN);
    assign done_o      = st_q.done;
    assign match_o     = st_q.match;
    assign match_vld_o = st_q.in_m;
    assign match_idx_o = st_q.idx;

    // ---------------- assertions ----------------
    for (genvar a = 0; a < N; a++) begin : g_chk
        logic [N-1:0] col_v;
        for (genvar b = 0; b < N; b++) begin : g_cb
            assign col_v[b] = match_o[b*N+a];
        end
        AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_o[a*N +: N])); // R2
        AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_v)); // R2
        AST_VLD_MATCHES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
            match_vld_o[a] == (|match_o[a*N +: N])); // R9
    end

    AST_MATCH_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o & ~st_q.req) == '0); // R2
    AST_PAIRS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> ((match_o & $past(match_o)) == $past(match_o))); // R6
    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.first |=> $stable(st_q.gptr) && $stable(st_q.aptr)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(st_q.req)); // R8

endmodule

// File: tb/islip_sched_tb.sv
`timescale 1ns/1ps
module islip_sched_tb;
    localparam int N  = 4;
    localparam int NW = 2;
    localparam int CW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [CW-1:0]   iters = '0;
    logic [N*N-1:0]  req = '0;
    logic            busy, done;
    logic [N*N-1:0]  match;
    logic [N-1:0]    mvld;
    logic [N*NW-1:0] midx;

    int errors = 0;
    int checks = 0;
    int gp[N];
    int ap[N];

    always #2 clk = ~clk;   // 250 MHz

    islip_sched #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .iters_i(iters), .req_i(req),
        .busy_o(busy), .done_o(done), .match_o(match),
        .match_vld_o(mvld), .match_idx_o(midx)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int clamp_it(input int it);
        if (it <= 0) return 1;
        if (it > N)  return N;
        return it;
    endfunction

    // reference model: R3 grant order, R4 accept order, R5 pointers, R6 rounds
    function automatic void model_slot(input logic [N*N-1:0] r, input int k,
                                       output logic [N*N-1:0] m,
                                       output logic [N*NW-1:0] ix,
                                       output logic [N-1:0] v);
        logic [N-1:0] inm, outm;
        int g[N];
        m = '0; ix = '0; v = '0; inm = '0; outm = '0;
        for (int rd = 0; rd < k; rd++) begin
            for (int j = 0; j < N; j++) begin
                g[j] = -1;
                if (!outm[j]) begin
                    for (int t = 0; t < N; t++) begin
                        int i;
                        i = (gp[j] + t) % N;
                        if (!inm[i] && r[i*N+j]) begin g[j] = i; break; end
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (!inm[i]) begin
                    for (int t = 0; t < N; t++) begin
                        int j;
                        j = (ap[i] + t) % N;
                        if (g[j] == i) begin
                            m[i*N+j] = 1'b1;
                            v[i] = 1'b1;
                            ix[i*NW +: NW] = NW'(j);
                            outm[j] = 1'b1;
                            if (rd == 0) begin
                                gp[j] = (i + 1) % N;
                                ap[i] = (j + 1) % N;
                            end
                            break;
                        end
                    end
                end
            end
            inm = inm | v;
        end
    endfunction

    task automatic run_slot(input logic [N*N-1:0] r, input int it, input bit poke,
                            output logic [N*N-1:0] got);
        logic [N*N-1:0]  em;
        logic [N*NW-1:0] ei, mask;
        logic [N-1:0]    ev;
        int k;
        k = clamp_it(it);
        model_slot(r, k, em, ei, ev);
        mask = '0;
        for (int i = 0; i < N; i++) if (ev[i]) mask[i*NW +: NW] = '1;
        @(negedge clk);
        start = 1'b1; req = r; iters = CW'(it);
        @(negedge clk);
        start = 1'b0; req = ~r;
        chk(busy == 1'b1, "R7 busy after start", 64'(busy), 64'd1);
        for (int c = 1; c <= k; c++) begin
            if (poke && c == 1) begin                 // R8 start while busy
                start = 1'b1; req = $urandom; iters = CW'(N);
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            if (c < k) begin
                chk(done == 1'b0, "R7 done early", 64'(done), 64'd0);
            end else begin
                chk(done == 1'b1 && busy == 1'b0, "R7/R8 done timing", {busy, done}, 64'd1);
                chk(match == em, "R2/R3/R4/R5/R6 match", 64'(match), 64'(em));
                chk(mvld == ev, "R9 valid", 64'(mvld), 64'(ev));
                chk((midx & mask) == ei, "R9 index", 64'(midx & mask), 64'(ei));
            end
        end
        got = match;
        @(negedge clk);
        chk(done == 1'b0 && match == em, "R7 pulse/hold", {done, match}, 64'(em));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [N*N-1:0] got;
        void'($urandom(32'h1A5B));
        for (int i = 0; i < N; i++) begin gp[i] = 0; ap[i] = 0; end
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && match == '0, "R1 reset outputs",
            {busy, done, match}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: pointers at 0 -> only input 0 / output 0 paired
        run_slot('1, 1, 1'b0, got);
        chk(got == 16'h0001, "R1 first slot pairing", 64'(got), 64'h1);
        // R10: full load, single round, desynchronised after N slots
        for (int s = 0; s < 2*N; s++) begin
            run_slot('1, 1, 1'b0, got);
            if (s >= N - 1)
                chk($countones(got) == N, "R10 full pairing", 64'($countones(got)), 64'(N));
        end
        // iteration-count clamping (R7) and later rounds (R6)
        run_slot('1, 0, 1'b0, got);
        run_slot(16'h1248, 7, 1'b0, got);
        run_slot(16'h000F, 4, 1'b1, got);   // one input, all outputs (R4 wrap)
        run_slot(16'h1111, 4, 1'b1, got);   // all inputs, one output (R3 wrap)
        // constrained random
        for (int s = 0; s < 300; s++) begin
            logic [N*N-1:0] r;
            r = $urandom;
            if (s % 3 == 0) r = r & $urandom;
            if (s % 3 == 1) r = r | $urandom;
            run_slot(r, int'($urandom_range(0, 5)), (s % 7 == 0), got);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule